// File: doc/BRIEF.md
# UART Status and Interrupt Combiner

This block keeps the eight-bit line status word of a FIFO-based UART and turns it into five level interrupt lines. The receive FIFO, the transmit data path and the error and break detectors elsewhere in the UART report to it through single-cycle event pulses. Software reaches it through two plain write ports: one for the control flags and one for the status word. Status bits are cleared by writing a zero to them. Writing a one to a status bit leaves it unchanged.

Transmit bookkeeping is handled locally. An accepted write to the transmit data register drops both the transmit-empty and transmit-end flags. An internal down-counter then raises both flags again after `DELAY_CYC` clock cycles. Another data write before that point reloads the counter. The transmit-end and receive-data-ready conditions share one interrupt line. The receive-error and break/overrun lines are present but always held low, because the detectors behind them are outside this block.

No data stream crosses this block's edge, so there is no valid/ready handshake. Every pin is a plain control or status signal, and every event pulse is taken in the cycle it is high.

Top module: `uart_irq_combiner`

## Requirements
- R1: After reset the status word reads 0x60 (only the transmit-empty and transmit-end bits set), all control flags are 0 and all five interrupt lines are low.
- R2: Status bit positions are: 0 data ready, 1 RX full, 2 parity error, 3 framing error, 4 break, 5 TX empty, 6 TX end, 7 error summary. On a status write, every bit written 0 is cleared at the next edge, and every bit written 1 keeps its value.
- R3: Event pulses set status bits at the next edge. `par_err_set` sets bit 2, `frm_err_set` sets bit 3 and `brk_set` sets bit 4. Each of these three also sets bit 7. When a set and a zero-write hit the same bit in the same cycle, the set wins.
- R4: `rx_pop` clears bit 1. If `rx_pop_last` is also high, bit 0 is cleared as well. A same-cycle set event for either bit wins over the pop.
- R5: `tx_wr_en` while the TE flag is 1 clears bits 5 and 6 at the next edge. While TE is 0, `tx_wr_en` has no effect.
- R6: After an accepted transmit write, bits 5 and 6 are set again exactly `DELAY_CYC` edges later. A newer accepted write restarts that count.
- R7: A control write that takes TE from 1 to 0 sets bit 5. A control write that changes the TIE flag, in either direction, also sets bit 5.
- R8: Control flag positions are: bit 2 TEIE, bit 4 RE, bit 5 TE, bit 6 RIE, bit 7 TIE. Other control bits are ignored. While RE is 0, `rx_ready_set` (bit 0) and `rx_full_set` (bit 1) have no effect.
- R9: Interrupt line 2 is RIE & bit 1. Line 3 is TIE & bit 5. Line 4 is (RIE & bit 0) | (TEIE & bit 6).
- R10: Interrupt lines 0 (receive error) and 1 (break/overrun) are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Control write strobe |
| ctrl_wr_data | input | 8 | Control write value |
| stat_wr_en | input | 1 | Status write strobe (zero bits clear) |
| stat_wr_data | input | 8 | Status write value |
| tx_wr_en | input | 1 | Transmit data register write strobe |
| rx_ready_set | input | 1 | Receive FIFO holds data (pulse) |
| rx_full_set | input | 1 | Receive FIFO reached its trigger level (pulse) |
| rx_pop | input | 1 | Receive FIFO read (pulse) |
| rx_pop_last | input | 1 | The read in this cycle empties the FIFO |
| par_err_set | input | 1 | Parity error seen (pulse) |
| frm_err_set | input | 1 | Framing error seen (pulse) |
| brk_set | input | 1 | Break seen (pulse) |
| stat_q | output | 8 | Current status word |
| irq | output | 5 | Level interrupt lines, index as in R9/R10 |

## Verification
A wrong status bit reaches `stat_q` one edge after the stimulus that produced it. If the affected flag is enabled, the same error appears on the matching `irq` line in that cycle, because the lines are combinational from registered state. A fault in the transmit delay counter shows up only at the reassertion edge. It appears as bits 5 and 6 returning one or more cycles early or late, or not returning after a restart. For that reason the bench compares the outputs on every cycle of that window, not only at its end.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // status word bit positions
  localparam int ST_DR   = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_PER  = 2;
  localparam int ST_FER  = 3;
  localparam int ST_BRK  = 4;
  localparam int ST_TXE  = 5;
  localparam int ST_TEND = 6;
  localparam int ST_ERS  = 7;
  localparam int ST_W    = 8;
  // control flag positions
  localparam int CT_TEIE = 2;
  localparam int CT_RE   = 4;
  localparam int CT_TE   = 5;
  localparam int CT_RIE  = 6;
  localparam int CT_TIE  = 7;
  // interrupt line order
  localparam int IRQ_RXERR  = 0;
  localparam int IRQ_BRKOVR = 1;
  localparam int IRQ_RXFULL = 2;
  localparam int IRQ_TXE    = 3;
  localparam int IRQ_TEND_DR = 4;
  localparam int NUM_IRQ    = 5;
  localparam logic [ST_W-1:0] STAT_RST = 8'h60;

  typedef struct packed {
    logic tie;
    logic rie;
    logic te;
    logic re;
    logic teie;
  } ctrl_flags_t;
endpackage

// File: rtl/uart_irqc_ctrl.sv
module uart_irqc_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output ctrl_flags_t flags,
  output logic        txe_set_req
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[3], wr_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (wr_en) begin
      flags.teie <= wr_data[CT_TEIE];
      flags.re   <= wr_data[CT_RE];
      flags.te   <= wr_data[CT_TE];
      flags.rie  <= wr_data[CT_RIE];
      flags.tie  <= wr_data[CT_TIE];
    end
  end

  // TE falling or TIE changing marks the transmit side empty
  assign txe_set_req = wr_en &&
                       ((flags.te && !wr_data[CT_TE]) ||
                        (flags.tie != wr_data[CT_TIE]));
endmodule

// File: rtl/uart_irqc_txtimer.sv
module uart_irqc_txtimer #(
  parameter int DELAY_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // the edge that takes the counter from 1 to 0 restores the flags
  assign expire = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/uart_irqc_status.sv
module uart_irqc_status
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_data,
  input  logic [ST_W-1:0] set_mask,
  input  logic [ST_W-1:0] pop_mask,
  input  logic            tx_restore,
  input  logic            txe_set,
  input  logic            tx_clr,
  output logic [ST_W-1:0] stat_q
);
  logic [ST_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) stat_d = stat_d & wr_data;
    stat_d = stat_d & ~pop_mask;
    stat_d = stat_d | set_mask;
    if (tx_restore) begin
      stat_d[ST_TXE]  = 1'b1;
      stat_d[ST_TEND] = 1'b1;
    end
    if (txe_set) stat_d[ST_TXE] = 1'b1;
    if (tx_clr) begin
      stat_d[ST_TXE]  = 1'b0;
      stat_d[ST_TEND] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/uart_irqc_map.sv
module uart_irqc_map
  import uart_irq_pkg::*;
(
  input  logic               rie,
  input  logic               tie,
  input  logic               teie,
  input  logic               dr,
  input  logic               rxf,
  input  logic               txe,
  input  logic               tend,
  output logic [NUM_IRQ-1:0] irq
);
  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_line
      if (g == IRQ_RXFULL) begin : g_rxf
        assign irq[g] = rie & rxf;
      end else if (g == IRQ_TXE) begin : g_txe
        assign irq[g] = tie & txe;
      end else if (g == IRQ_TEND_DR) begin : g_shared
        assign irq[g] = (rie & dr) | (teie & tend);
      end else begin : g_quiet
        assign irq[g] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uart_irq_pkg::*;
#(
  parameter int DELAY_CYC = 1250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_en,
  input  logic [7:0]         ctrl_wr_data,
  input  logic               stat_wr_en,
  input  logic [ST_W-1:0]    stat_wr_data,
  input  logic               tx_wr_en,
  input  logic               rx_ready_set,
  input  logic               rx_full_set,
  input  logic               rx_pop,
  input  logic               rx_pop_last,
  input  logic               par_err_set,
  input  logic               frm_err_set,
  input  logic               brk_set,
  output logic [ST_W-1:0]    stat_q,
  output logic [NUM_IRQ-1:0] irq
);
  ctrl_flags_t     ctl;
  logic            txe_set_req;
  logic            tx_accept;
  logic            tx_expire;
  logic [ST_W-1:0] set_mask;
  logic [ST_W-1:0] pop_mask;

  uart_irqc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_en), .wr_data(ctrl_wr_data),
    .flags(ctl), .txe_set_req(txe_set_req)
  );

  assign tx_accept = tx_wr_en && ctl.te;

  uart_irqc_txtimer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tx_accept), .expire(tx_expire)
  );

  always_comb begin
    set_mask          = '0;
    set_mask[ST_DR]   = rx_ready_set & ctl.re;
    set_mask[ST_RXF]  = rx_full_set & ctl.re;
    set_mask[ST_PER]  = par_err_set;
    set_mask[ST_FER]  = frm_err_set;
    set_mask[ST_BRK]  = brk_set;
    set_mask[ST_ERS]  = par_err_set | frm_err_set | brk_set;
    pop_mask          = '0;
    pop_mask[ST_RXF]  = rx_pop;
    pop_mask[ST_DR]   = rx_pop & rx_pop_last;
  end

  uart_irqc_status u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr_en), .wr_data(stat_wr_data),
    .set_mask(set_mask), .pop_mask(pop_mask), .tx_restore(tx_expire),
    .txe_set(txe_set_req), .tx_clr(tx_accept), .stat_q(stat_q)
  );

  uart_irqc_map u_map (
    .rie(ctl.rie), .tie(ctl.tie), .teie(ctl.teie),
    .dr(stat_q[ST_DR]), .rxf(stat_q[ST_RXF]),
    .txe(stat_q[ST_TXE]), .tend(stat_q[ST_TEND]),
    .irq(irq)
  );
endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr_en,
  input logic [7:0] ctrl_wr_data,
  input logic       stat_wr_en,
  input logic [7:0] stat_wr_data,
  input logic       tx_wr_en,
  input logic       rx_pop,
  input logic       par_err_set,
  input logic       te,
  input logic       re,
  input logic [7:0] stat_q,
  input logic [4:0] irq
);
  AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> (stat_q == 8'h60 && irq == 5'd0)); // R1

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en && !stat_wr_data[2] && !par_err_set |=> !stat_q[2]); // R2

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en && stat_wr_data[0] && stat_q[0] && !rx_pop |=> stat_q[0]); // R2

  AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_en && te |=> !stat_q[5] && !stat_q[6]); // R5

  AST_TE_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && te && !ctrl_wr_data[5] && !tx_wr_en |=> stat_q[5]); // R7

  AST_RE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !re && !stat_q[0] |=> !stat_q[0]); // R8

  AST_RXFULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq[2] |-> stat_q[1]); // R9

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1:0] == 2'b00); // R10
endmodule

bind uart_irq_combiner uart_irq_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
  .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .tx_wr_en(tx_wr_en),
  .rx_pop(rx_pop), .par_err_set(par_err_set), .te(ctl.te), .re(ctl.re),
  .stat_q(stat_q), .irq(irq)
);

// File: tb/uart_irq_combiner_tb.sv
module uart_irq_combiner_tb;
  localparam int D = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr_en = 0, stat_wr_en = 0, tx_wr_en = 0;
  logic [7:0] ctrl_wr_data = 0, stat_wr_data = 0;
  logic rx_ready_set = 0, rx_full_set = 0, rx_pop = 0, rx_pop_last = 0;
  logic par_err_set = 0, frm_err_set = 0, brk_set = 0;
  logic [7:0] stat_q;
  logic [4:0] irq;

  always #2 clk = ~clk; // 250 MHz

  uart_irq_combiner #(.DELAY_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .tx_wr_en(tx_wr_en),
    .rx_ready_set(rx_ready_set), .rx_full_set(rx_full_set), .rx_pop(rx_pop),
    .rx_pop_last(rx_pop_last), .par_err_set(par_err_set), .frm_err_set(frm_err_set),
    .brk_set(brk_set), .stat_q(stat_q), .irq(irq)
  );

  typedef struct {
    logic [7:0] st;
    logic [4:0] ir;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] m_st;
  logic [7:0] m_ct;
  int m_cnt;

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (stat_q !== e.st || irq !== e.ir) begin
        fails++;
        $display("FAIL %s: stat=%02h irq=%05b expected stat=%02h irq=%05b",
                 e.tag, stat_q, irq, e.st, e.ir);
      end
    end
  end

  // driver: inputs are already set; predict the next state and push it
  task automatic cyc(string tag);
    logic [7:0] ns;
    logic [7:0] nc;
    exp_t e;
    bit acc;
    ns = m_st;
    if (stat_wr_en) ns = ns & stat_wr_data;
    if (rx_pop) begin
      ns[1] = 1'b0;
      if (rx_pop_last) ns[0] = 1'b0;
    end
    if (m_ct[4] && rx_ready_set) ns[0] = 1'b1;
    if (m_ct[4] && rx_full_set) ns[1] = 1'b1;
    if (par_err_set) begin ns[2] = 1'b1; ns[7] = 1'b1; end
    if (frm_err_set) begin ns[3] = 1'b1; ns[7] = 1'b1; end
    if (brk_set)     begin ns[4] = 1'b1; ns[7] = 1'b1; end
    acc = tx_wr_en && m_ct[5];
    if (m_cnt == 1 && !acc) begin ns[5] = 1'b1; ns[6] = 1'b1; end
    if (ctrl_wr_en && ((m_ct[5] && !ctrl_wr_data[5]) || (m_ct[7] != ctrl_wr_data[7])))
      ns[5] = 1'b1;
    if (acc) begin ns[5] = 1'b0; ns[6] = 1'b0; m_cnt = D; end
    else if (m_cnt != 0) m_cnt--;
    nc = ctrl_wr_en ? (ctrl_wr_data & 8'hF4) : m_ct;
    m_st = ns;
    m_ct = nc;
    e.st = ns;
    e.ir = {(nc[6] & ns[0]) | (nc[2] & ns[6]), nc[7] & ns[5], nc[6] & ns[1], 2'b00};
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    ctrl_wr_en = 0; stat_wr_en = 0; tx_wr_en = 0;
    rx_ready_set = 0; rx_full_set = 0; rx_pop = 0; rx_pop_last = 0;
    par_err_set = 0; frm_err_set = 0; brk_set = 0;
  endtask

  task automatic ctrl_w(logic [7:0] v, string tag);
    ctrl_wr_en = 1; ctrl_wr_data = v; cyc(tag);
  endtask

  task automatic stat_w(logic [7:0] v, string tag);
    stat_wr_en = 1; stat_wr_data = v; cyc(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_st = 8'h60; m_ct = 8'h00; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1, "R1 reset state");
    // RE off: receive events ignored
    rx_ready_set = 1; rx_full_set = 1; cyc("R8 RE=0 ignores rx sets");
    ctrl_w(8'hFF, "R8 reserved control bits ignored, R9 lines");
    rx_ready_set = 1; cyc("R3 data ready set, R9 shared line");
    rx_full_set = 1; cyc("R3 rx full set, R9 line 2");
    stat_w(8'hFE, "R2 zero clears data ready");
    stat_w(8'hFF, "R2 ones keep status");
    par_err_set = 1; cyc("R3 parity sets summary");
    frm_err_set = 1; brk_set = 1; cyc("R3 framing and break");
    stat_w(8'h00, "R2 clear all");
    par_err_set = 1; stat_wr_en = 1; stat_wr_data = 8'h00; cyc("R3 set wins over clear");
    stat_w(8'h00, "R2 clear again");
    ctrl_w(8'hD4, "R7 TE fall sets TX empty");
    stat_w(8'h00, "R2 clear TX empty");
    ctrl_w(8'h54, "R7 TIE change sets TX empty");
    stat_w(8'hDF, "R2 clear bit 5 only");
    tx_wr_en = 1; cyc("R5 TE=0 write ignored");
    idle(2, "R5 still ignored");
    ctrl_w(8'hF4, "R7 TE rise, TIE change");
    tx_wr_en = 1; cyc("R5 accepted write clears");
    idle(8, "R6 waiting");
    tx_wr_en = 1; cyc("R6 restart");
    idle(D + 3, "R6 reassert window");
    rx_ready_set = 1; rx_full_set = 1; cyc("R3 rx events again");
    rx_pop = 1; cyc("R4 pop clears full");
    rx_pop = 1; rx_pop_last = 1; cyc("R4 last pop clears ready");
    rx_pop = 1; rx_pop_last = 1; rx_ready_set = 1; cyc("R4 set wins over pop");
    ctrl_w(8'h00, "R9 lines drop with enables, R10");
    idle(2, "R10 quiet");
    @(posedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule